// File: doc/BRIEF.md
# Bounded String Search Engine

This block scans memory for one character, from a start address up toward an end address. A byte mode compares 8-bit elements and a halfword mode compares 16-bit elements. The caller presents the start address, the end address, a 32-bit character word and the mode with a one-cycle `start` strobe. The engine then fetches elements one at a time over a valid/ready request port with a single outstanding response. It finishes with a one-cycle `done` pulse that carries a two-bit condition code and the updated start and end addresses.

There are three outcomes. The character is found, the end address is reached, or a work cap on processed bytes runs out. When the cap runs out, the returned start address lets the caller resume the search by issuing the operation again. Before any search begins, the engine checks the reserved upper bits of the character word. A character word with reserved bits set ends the operation at once with a specification error.

Top module: `strscan_engine`

## Requirements
- R1: In byte mode, a character word with any of bits 31:8 set gives `done` one cycle after the `start` edge, with `spec_err`=1, `cc`=0, `new_start`=`start_addr` and `new_end`=`end_addr`, and no memory request is issued.
- R2: In halfword mode, only bits 31:16 are reserved and give the R1 outcome. Bits 15:8 form part of the character.
- R3: Before each fetch, if the current address equals the effective end, the operation ends with `cc`=2 and both address outputs equal the inputs. When `start_addr` equals `end_addr`, `done` comes two cycles after the `start` edge and no request is issued.
- R4: When the fetched element equals the character, the operation ends with `cc`=1, `new_end` set to that element's address and `new_start`=`start_addr`.
- R5: Once CAP_BYTES bytes have been processed (default 8192), the operation ends with `cc`=3, `new_start`=`start_addr`+CAP_BYTES and `new_end`=`end_addr`. The cap test comes before the end test.
- R6: Byte mode fetches consecutive addresses with `mem_req_half`=0 and compares `mem_rsp_data[7:0]`. Halfword mode steps the address by 2 with `mem_req_half`=1 and compares all of `mem_rsp_data[15:0]`, where the byte at the lower address sits in bits 15:8.
- R7: In halfword mode, if `start_addr` and `end_addr` differ in bit 0, the effective end is `end_addr`+1. `new_end` still returns `end_addr` when the end is reached.
- R8: A request holds `mem_req_valid` and a stable `mem_req_addr` until `mem_req_ready`. Only one request is outstanding, and the comparison waits for `mem_rsp_valid`.
- R9: `done` is high for exactly one cycle per operation.
- R10: Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation; ignored while busy |
| half_mode | input | 1 | 1 selects halfword elements, 0 selects bytes |
| char_word | input | 32 | Character in the low bits; the upper bits are reserved |
| start_addr | input | 64 | First address to scan |
| end_addr | input | 64 | Address at which the scan stops |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_half | output | 1 | Read size: 1 for halfword, 0 for byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code: 1 found, 2 end reached, 3 cap reached, 0 for a specification error |
| spec_err | output | 1 | Reserved character bits were set |
| new_start | output | 64 | Updated start address |
| new_end | output | 64 | Updated end address |
| busy | output | 1 | An operation is in progress |

## Verification
The assertions take the following for granted about the inputs:
- the memory returns exactly one response per accepted request, and never before the request is accepted;
- `start` is raised only while `busy` is low;
- CAP_BYTES is even, so the halfword byte count stays even.

The bench memory model meets these conditions. It records each accepted request and answers it exactly once on the next cycle, and it throttles `mem_req_ready` in a repeating pattern. The bench issues each operation only after the previous `done`. The sweeps use a small cap and cover both modes, matching and odd end parities, and start addresses near the top of the address space.

// File: rtl/strscan_pkg.sv
// Shared types for the string search engine.
package strscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT
    } scan_state_e;

    localparam logic [1:0] CC_NONE    = 2'd0;
    localparam logic [1:0] CC_FOUND   = 2'd1;
    localparam logic [1:0] CC_END     = 2'd2;
    localparam logic [1:0] CC_PARTIAL = 2'd3;
endpackage

// File: rtl/strscan_guard.sv
// Operand guard: checks the reserved bits of the character word for the
// selected mode, extracts the search key and derives the effective end
// address. It is purely combinational and assumes CHAR_W > 16.
module strscan_guard #(
    parameter int ADDR_W = 64,
    parameter int CHAR_W = 32,
    parameter int KEY_W  = 16
) (
    input  logic              half_mode,
    input  logic [CHAR_W-1:0] char_word,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              spec_bad,
    output logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] eff_end
);
    localparam int BYTE_W = KEY_W / 2;

    logic parity_gap;

    // Reserved-bit test and key extraction for the selected mode.
    always_comb begin
        if (half_mode) begin
            spec_bad = |char_word[CHAR_W-1:KEY_W];
            key      = char_word[KEY_W-1:0];
        end else begin
            spec_bad = |char_word[CHAR_W-1:BYTE_W];
            key      = {{(KEY_W-BYTE_W){1'b0}}, char_word[BYTE_W-1:0]};
        end
    end

    // Halfword scans stop one byte further when the end parity differs.
    always_comb begin
        parity_gap = half_mode & (start_addr[0] ^ end_addr[0]);
        eff_end    = end_addr + {{(ADDR_W-1){1'b0}}, parity_gap};
    end
endmodule

// File: rtl/strscan_match.sv
// Element comparator: compares the returned read data with the latched key.
// Byte mode looks only at the low byte of the response.
module strscan_match #(
    parameter int KEY_W = 16
) (
    input  logic             half_q,
    input  logic [KEY_W-1:0] key_q,
    input  logic [KEY_W-1:0] rsp_data,
    output logic             hit
);
    localparam int BYTE_W = KEY_W / 2;

    // Width-dependent equality test.
    always_comb begin
        if (half_q) hit = (rsp_data == key_q);
        else        hit = (rsp_data[BYTE_W-1:0] == key_q[BYTE_W-1:0]);
    end
endmodule

// File: rtl/strscan_fsm.sv
// Search controller. It latches the operands on start, tests the cap and
// then the end before each fetch, issues one read at a time and registers
// the result with a one-cycle done pulse.
// Assumes: CAP_BYTES is even; start comes only while idle; exactly one
// response is returned per accepted request.
module strscan_fsm
    import strscan_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CAP_BYTES = 8192,
    parameter int KEY_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              half_mode,
    input  logic              spec_bad,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [ADDR_W-1:0] eff_end,
    input  logic [KEY_W-1:0]  key_in,
    output logic [KEY_W-1:0]  key_q,
    output logic              half_q,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              hit,
    output logic              done,
    output logic [1:0]        cc,
    output logic              spec_err,
    output logic [ADDR_W-1:0] new_start,
    output logic [ADDR_W-1:0] new_end,
    output logic              busy
);
    localparam int          LEN_W   = $clog2(CAP_BYTES + 1);
    localparam logic [LEN_W-1:0] CAP_LEN = LEN_W'(CAP_BYTES);

    scan_state_e       state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] end_q;
    logic [ADDR_W-1:0] eff_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  step;

    // Current element address and step size.
    always_comb begin
        cur_addr = base_q + ADDR_W'(len_q);
        step     = half_q ? LEN_W'(2) : LEN_W'(1);
    end

    // Port views of the state.
    always_comb begin
        mem_req_valid = (state == ST_REQ);
        mem_req_addr  = cur_addr;
        busy          = (state != ST_IDLE);
    end

    // Operation sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            end_q     <= '0;
            eff_q     <= '0;
            len_q     <= '0;
            key_q     <= '0;
            half_q    <= 1'b0;
            done      <= 1'b0;
            cc        <= CC_NONE;
            spec_err  <= 1'b0;
            new_start <= '0;
            new_end   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= start_addr;
                        end_q  <= end_addr;
                        eff_q  <= eff_end;
                        key_q  <= key_in;
                        half_q <= half_mode;
                        len_q  <= '0;
                        if (spec_bad) begin
                            done      <= 1'b1;
                            cc        <= CC_NONE;
                            spec_err  <= 1'b1;
                            new_start <= start_addr;
                            new_end   <= end_addr;
                        end else begin
                            state <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (len_q >= CAP_LEN) begin
                        done      <= 1'b1;
                        cc        <= CC_PARTIAL;
                        spec_err  <= 1'b0;
                        new_start <= cur_addr;
                        new_end   <= end_q;
                        state     <= ST_IDLE;
                    end else if (cur_addr == eff_q) begin
                        done      <= 1'b1;
                        cc        <= CC_END;
                        spec_err  <= 1'b0;
                        new_start <= base_q;
                        new_end   <= end_q;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (hit) begin
                            done      <= 1'b1;
                            cc        <= CC_FOUND;
                            spec_err  <= 1'b0;
                            new_start <= base_q;
                            new_end   <= cur_addr;
                            state     <= ST_IDLE;
                        end else begin
                            len_q <= len_q + step;
                            state <= ST_CHECK;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= CAP_LEN);

    // R6
    half_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && half_q) |-> !len_q[0]);

    // R1
    spec_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && spec_err) |-> (cc == CC_NONE && !$past(busy)));
endmodule

// File: rtl/strscan_engine.sv
// Top level of the bounded string search engine. It joins the operand
// guard, the controller and the element comparator. Assumes the memory
// answers each accepted request exactly once.
module strscan_engine
    import strscan_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CHAR_W    = 32,
    parameter int CAP_BYTES = 8192,
    parameter int KEY_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              half_mode,
    input  logic [CHAR_W-1:0] char_word,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_half,
    input  logic              mem_rsp_valid,
    input  logic [KEY_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic [1:0]        cc,
    output logic              spec_err,
    output logic [ADDR_W-1:0] new_start,
    output logic [ADDR_W-1:0] new_end,
    output logic              busy
);
    logic              spec_bad;
    logic [KEY_W-1:0]  key;
    logic [KEY_W-1:0]  key_q;
    logic [ADDR_W-1:0] eff_end;
    logic              half_q;
    logic              hit;

    strscan_guard #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .KEY_W(KEY_W)) i_guard (
        .half_mode (half_mode),
        .char_word (char_word),
        .start_addr(start_addr),
        .end_addr  (end_addr),
        .spec_bad  (spec_bad),
        .key       (key),
        .eff_end   (eff_end)
    );

    strscan_fsm #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES), .KEY_W(KEY_W)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .half_mode    (half_mode),
        .spec_bad     (spec_bad),
        .start_addr   (start_addr),
        .end_addr     (end_addr),
        .eff_end      (eff_end),
        .key_in       (key),
        .key_q        (key_q),
        .half_q       (half_q),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .hit          (hit),
        .done         (done),
        .cc           (cc),
        .spec_err     (spec_err),
        .new_start    (new_start),
        .new_end      (new_end),
        .busy         (busy)
    );

    strscan_match #(.KEY_W(KEY_W)) i_match (
        .half_q  (half_q),
        .key_q   (key_q),
        .rsp_data(mem_rsp_data),
        .hit     (hit)
    );

    // Read size follows the latched mode.
    always_comb mem_req_half = half_q;

    // R6
    found_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cc == CC_FOUND && half_q) |-> (new_end[0] == new_start[0]));

    // R3
    end_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cc == CC_END) |-> !spec_err);
endmodule

// File: tb/test_strscan_engine.sv
`timescale 1ns/1ps
module test_strscan_engine;
    localparam int AW  = 64;
    localparam int CAP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          half_mode;
    logic [31:0]   char_word;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] end_addr;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_half;
    logic          mem_rsp_valid;
    logic [15:0]   mem_rsp_data;
    logic          done;
    logic [1:0]    cc;
    logic          spec_err;
    logic [AW-1:0] new_start;
    logic [AW-1:0] new_end;
    logic          busy;

    always #10 clk = ~clk;

    strscan_engine #(.ADDR_W(AW), .CAP_BYTES(CAP)) i_strscan_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .half_mode(half_mode),
        .char_word(char_word), .start_addr(start_addr), .end_addr(end_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_half(mem_req_half),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .cc(cc), .spec_err(spec_err), .new_start(new_start),
        .new_end(new_end), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int req_count = 0;
    int cyc = 0;
    bit finished = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr;
    logic          pend_half;

    function automatic logic [7:0] bval(logic [AW-1:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: one response per accepted request, the cycle after.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pend_half ? {bval(pend_addr), bval(pend_addr + 1)}
                                          : {8'hA5, bval(pend_addr)};
                pend = 1'b0;
            end
            mem_req_ready = (cyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                pend      = 1'b1;
                pend_addr = mem_req_addr;
                pend_half = mem_req_half;
                req_count++;
            end
        end
    end

    // Requirement model of one operation.
    task automatic model(input bit half, input logic [AW-1:0] s, input logic [AW-1:0] e,
                         input logic [31:0] c, output logic [1:0] xcc, output bit xspec,
                         output logic [AW-1:0] xs, output logic [AW-1:0] xe, output int xreq);
        logic [AW-1:0] eff;
        logic [AW-1:0] a;
        logic [15:0]   el;
        int len;
        xspec = half ? (c[31:16] != 0) : (c[31:8] != 0);
        xs = s; xe = e; xreq = 0; xcc = 2'd0;
        if (xspec) return;
        eff = e + ((half && (s[0] ^ e[0])) ? 64'd1 : 64'd0);
        len = 0;
        forever begin
            a = s + AW'(len);
            if (len >= CAP) begin xcc = 2'd3; xs = a; return; end
            if (a == eff) begin xcc = 2'd2; return; end
            xreq++;
            el = half ? {bval(a), bval(a + 1)} : {8'h00, bval(a)};
            if ((half && el == c[15:0]) || (!half && el[7:0] == c[7:0])) begin
                xcc = 2'd1; xe = a; return;
            end
            len += half ? 2 : 1;
        end
    endtask

    task automatic run_op(input bit half, input logic [AW-1:0] s, input logic [AW-1:0] e,
                          input logic [31:0] c, input string req, output int lat);
        logic [1:0] xcc; bit xspec; logic [AW-1:0] xs; logic [AW-1:0] xe; int xreq; int base;
        model(half, s, e, c, xcc, xspec, xs, xe, xreq);
        @(negedge clk);
        base = req_count;
        start = 1'b1; half_mode = half; char_word = c; start_addr = s; end_addr = e;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        chk(done, req, "done seen", AW'(done), 64'd1);
        chk(cc == xcc, req, "cc", AW'(cc), AW'(xcc));
        chk(spec_err == xspec, req, "spec_err", AW'(spec_err), AW'(xspec));
        chk(new_start == xs, req, "new_start", new_start, xs);
        chk(new_end == xe, req, "new_end", new_end, xe);
        chk((req_count - base) == xreq, req, "fetches", AW'(req_count - base), AW'(xreq));
        @(negedge clk);
        // R9: single-cycle pulse
        chk(!done, "R9", "done pulse width", AW'(done), 64'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [AW-1:0] starts [3];
        starts[0] = 64'h100; starts[1] = 64'h1F3; starts[2] = 64'hFFFF_FFFF_FFFF_FFF0;
        rst_n = 1'b0; start = 1'b0; half_mode = 1'b0; char_word = '0;
        start_addr = '0; end_addr = '0;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_req_valid, "R9", "reset outputs idle",
            AW'({done, busy, mem_req_valid}), 64'd0);
        rst_n = 1'b1;

        // R1: byte-mode reserved bits
        run_op(1'b0, 64'h200, 64'h210, 32'h0000_0100, "R1", lat);
        chk(lat == 1, "R1", "spec latency", AW'(lat), 64'd1);
        run_op(1'b0, 64'h200, 64'h210, 32'h8000_0000, "R1", lat);
        // R2: halfword reserved bits and allowed bits 15:8
        run_op(1'b1, 64'h200, 64'h210, 32'h0001_0000, "R2", lat);
        chk(lat == 1, "R2", "spec latency", AW'(lat), 64'd1);
        run_op(1'b1, 64'h200, 64'h220, {16'h0, bval(64'h206), bval(64'h207)}, "R2", lat);
        // R3: empty range
        run_op(1'b0, 64'h300, 64'h300, 32'h0, "R3", lat);
        chk(lat == 2, "R3", "empty latency", AW'(lat), 64'd2);
        // R5: cap precedes end, and cap in both modes
        run_op(1'b0, 64'h400, 64'h400 + CAP, {24'h0, bval(64'h400 + 100)}, "R5", lat);
        run_op(1'b0, 64'h400, 64'h400 + 100, {24'h0, bval(64'h400 + 100)}, "R5", lat);
        run_op(1'b1, 64'h400, 64'h400 + 100, {16'h0, bval(64'h464), bval(64'h465)}, "R5", lat);
        // R7: odd parity gap in halfword mode
        run_op(1'b1, 64'h500, 64'h505, {16'h0, bval(64'h600), bval(64'h601)}, "R7", lat);
        run_op(1'b1, 64'h501, 64'h504, {16'h0, bval(64'h600), bval(64'h601)}, "R7", lat);
        // R10: wrap across zero
        run_op(1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8, {24'h0, bval(64'h2)}, "R10", lat);
        run_op(1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8, {16'h0, bval(64'h2), bval(64'h3)}, "R10", lat);

        // R4 R6 R3 R7 sweep over modes, starts, lengths, present/absent characters
        for (int h = 0; h < 2; h++) begin
            for (int si = 0; si < 3; si++) begin
                for (int l = 0; l <= 40; l += 3) begin
                    logic [AW-1:0] s;
                    logic [AW-1:0] tgt;
                    s = starts[si];
                    tgt = s + AW'(h != 0 ? ((l / 2) & ~1) : (l / 2));
                    if (h != 0) begin
                        run_op(1'b1, s, s + AW'(l), {16'h0, bval(tgt), bval(tgt + 1)}, "R4", lat);
                        run_op(1'b1, s, s + AW'(l), {16'h0, bval(s + 100), bval(s + 101)}, "R6", lat);
                    end else begin
                        run_op(1'b0, s, s + AW'(l), {24'h0, bval(tgt)}, "R4", lat);
                        run_op(1'b0, s, s + AW'(l), {24'h0, bval(s + 100)}, "R6", lat);
                    end
                end
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule